// File: doc/BRIEF.md
# Memory PHY Training Step Pacer

This block drives a memory interface training state machine through a fixed, ordered list of steps. A start pulse captures the configuration and enters step 0. The pacer then leaves each step on one of two events: the step raises its done flag, or a watchdog of 2^n clock cycles runs out. Expiry does not abort training. The pacer moves on to the next step, reloads the watchdog, and records the expiry in a sticky per-step timeout flag. When the last step ends, busy drops and a training-complete level is held until the next start.

While the write-leveling step is active, the block emits a pulse that paces the write CAS indications. The pulse period is 16 or 32 cycles, chosen by a select bit. While the strobe/data training step is active, it emits a turnaround pulse at a programmable period of 0 to 31 cycles, which sets the gap between reads and writes. The capture registers reset to these values:

- watchdog exponent: 0
- spacing select: 0
- turnaround delay: 15

All pins are plain control and status signals; there is no streaming interface, so no back-pressure applies. The PHY delay adjustment itself is outside this block.

Top module: `phy_train_pacer`

## Requirements
- R1: After reset, `busy_o`, `train_done_o`, `timeout_o`, `step_start_o`, `wl_cas_o` and `turn_o` are all 0, and `step_o` is 0.
- R2: A `start_i` seen while idle causes the following on the next cycle:
  - `busy_o` is 1 and `step_o` is 0.
  - `step_start_o` is 4'b0001.
  - `train_done_o` and all `timeout_o` bits are cleared.
- R3: A step that never reports done stays active for exactly 2^n cycles, where n is `wd_exp_i` as captured at start. It then advances to the next step, and the watchdog restarts from zero.
- R4: If `step_done_i[k]` is high in a cycle while step k is active, the pacer leaves step k at the next clock. If done and watchdog expiry fall in the same cycle, the step counts as done.
- R5: `timeout_o[k]` is set when step k ends by expiry, and it stays set until the next accepted start. It is never set for a step that ends by done.
- R6: Each entry into step k raises `step_start_o` bit k for exactly one cycle. At most one bit of `step_start_o` is high at a time.
- R7: When the last step ends, `busy_o` falls and `train_done_o` rises. `train_done_o` stays high while idle until the next accepted start.
- R8: `start_i` has no effect while `busy_o` is high.
- R9: `wl_cas_o` pulses only in the write-leveling step (index 1). It first fires on cycle P of the step (counting from 1) and then every P cycles, where P is 16 when `wl_space_sel_i` is 0 and 32 when it is 1.
- R10: `turn_o` pulses only in the strobe/data training step (index 2), every D cycles with the first pulse on cycle D. D is `turn_dly_i`, and a value of 0 behaves as 1.
- R11: The configuration inputs are captured at start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a training run (idle only) |
| step_done_i | input | NUM_STEPS | Per-step completion flags |
| wd_exp_i | input | 5 | Watchdog exponent n, period 2^n cycles |
| wl_space_sel_i | input | 1 | Write-leveling spacing: 0 = 16, 1 = 32 cycles |
| turn_dly_i | input | 5 | Read/write turnaround period in cycles |
| step_o | output | STEP_W | Index of the active step |
| step_start_o | output | NUM_STEPS | One-cycle step entry strobes |
| busy_o | output | 1 | A training run is in progress |
| train_done_o | output | 1 | Run finished, held until next start |
| timeout_o | output | NUM_STEPS | Sticky per-step expiry flags |
| wl_cas_o | output | 1 | Write-leveling CAS spacing pulse |
| turn_o | output | 1 | Turnaround pulse |

## Verification
The assertions check the following on every cycle:
- the watchdog count never passes its limit;
- strobes are one-hot;
- timeout flags never clear mid-run;
- a done flag advances the step;
- start is ignored while busy;
- spacing pulses appear only in their own step and are never back to back when the period exceeds one.

Some behaviours only the bench scenarios can show: the exact number of cycles spent in each step under mixes of early done, late done and expiry (including done on the expiry cycle), the exact pulse counts for each spacing setting, and that configuration changes during a run are ignored.

// File: rtl/phy_train_pkg.sv
package phy_train_pkg;
  localparam int unsigned CFG_W = 5;

  typedef struct packed {
    logic [CFG_W-1:0] wd_exp;
    logic             wl_sel;
    logic [CFG_W-1:0] turn_dly;
  } train_cfg_t;

  localparam train_cfg_t CFG_RESET = '{wd_exp: '0, wl_sel: 1'b0, turn_dly: 5'd15};

  localparam int unsigned WL_SHORT = 16;
  localparam int unsigned WL_LONG  = 32;
endpackage

// File: rtl/trn_watchdog.sv
module trn_watchdog #(
  parameter int unsigned EXP_W = 5,
  localparam int unsigned CNT_W = 1 << EXP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit    = (CNT_W'(1) << exp_i) - CNT_W'(1);
  assign expire_o = (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  // R3: the count stays within the programmed window while running
  assert_wd_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> (cnt_q <= limit));
endmodule

// File: rtl/trn_pulse_gen.sv
module trn_pulse_gen #(
  parameter int unsigned PER_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [PER_W-1:0] period_i,
  output logic             pulse_o
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] eff;
  logic             wrap;

  assign eff     = (period_i == '0) ? PER_W'(1) : period_i;
  assign wrap    = (cnt_q == eff - PER_W'(1));
  assign pulse_o = active_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (wrap)      cnt_q <= '0;
    else                cnt_q <= cnt_q + PER_W'(1);
  end

  // R9 and R10: a period above one never yields back-to-back pulses
  assert_pulse_spacing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && eff > PER_W'(1)) |=> !pulse_o);
endmodule

// File: rtl/phy_train_pacer.sv
module phy_train_pacer #(
  parameter int unsigned NUM_STEPS = 4,
  parameter int unsigned WL_STEP   = 1,
  parameter int unsigned DQS_STEP  = 2,
  localparam int unsigned STEP_W   = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NUM_STEPS-1:0] step_done_i,
  input  logic [4:0]           wd_exp_i,
  input  logic                 wl_space_sel_i,
  input  logic [4:0]           turn_dly_i,
  output logic [STEP_W-1:0]    step_o,
  output logic [NUM_STEPS-1:0] step_start_o,
  output logic                 busy_o,
  output logic                 train_done_o,
  output logic [NUM_STEPS-1:0] timeout_o,
  output logic                 wl_cas_o,
  output logic                 turn_o
);
  import phy_train_pkg::*;

  localparam int unsigned PER_W = 6;
  localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(NUM_STEPS - 1);
  localparam logic [STEP_W-1:0] WL_IDX   = STEP_W'(WL_STEP);
  localparam logic [STEP_W-1:0] DQS_IDX  = STEP_W'(DQS_STEP);

  train_cfg_t           cfg_q;
  logic [STEP_W-1:0]    step_q;
  logic                 busy_q, done_q;
  logic [NUM_STEPS-1:0] flag_q, sstart_q;
  logic                 accept, expire, step_fin, adv, is_last;

  assign accept   = start_i && !busy_q;
  assign step_fin = step_done_i[step_q];
  assign adv      = busy_q && (step_fin || expire);
  assign is_last  = (step_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET;
    else if (accept) cfg_q <= '{wd_exp: wd_exp_i, wl_sel: wl_space_sel_i, turn_dly: turn_dly_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
      flag_q <= '0; sstart_q <= '0;
    end else if (accept) begin
      step_q <= '0; busy_q <= 1'b1; done_q <= 1'b0;
      flag_q <= '0; sstart_q <= NUM_STEPS'(1);
    end else if (adv) begin
      if (expire && !step_fin) flag_q[step_q] <= 1'b1;
      if (is_last) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        sstart_q <= '0;
      end else begin
        step_q   <= step_q + STEP_W'(1);
        sstart_q <= NUM_STEPS'(1) << (step_q + STEP_W'(1));
      end
    end else begin
      sstart_q <= '0;
    end
  end

  trn_watchdog #(.EXP_W(CFG_W)) u_wd (
    .clk_i, .rst_ni,
    .clear_i (!busy_q || adv),
    .exp_i   (cfg_q.wd_exp),
    .expire_o(expire)
  );

  generate
    if (WL_STEP < NUM_STEPS) begin : g_wl
      trn_pulse_gen #(.PER_W(PER_W)) u_wl (
        .clk_i, .rst_ni,
        .active_i(busy_q && step_q == WL_IDX),
        .period_i(cfg_q.wl_sel ? PER_W'(WL_LONG) : PER_W'(WL_SHORT)),
        .pulse_o (wl_cas_o)
      );
    end else begin : g_no_wl
      assign wl_cas_o = 1'b0;
    end
    if (DQS_STEP < NUM_STEPS) begin : g_turn
      trn_pulse_gen #(.PER_W(PER_W)) u_turn (
        .clk_i, .rst_ni,
        .active_i(busy_q && step_q == DQS_IDX),
        .period_i({1'b0, cfg_q.turn_dly}),
        .pulse_o (turn_o)
      );
    end else begin : g_no_turn
      assign turn_o = 1'b0;
    end
  endgenerate

  assign step_o       = step_q;
  assign step_start_o = sstart_q;
  assign busy_o       = busy_q;
  assign train_done_o = done_q;
  assign timeout_o    = flag_q;

  assert_done_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_fin && !is_last) |=> (step_q == STEP_W'($past(step_q) + STEP_W'(1))));
  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  assert_start_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sstart_q));
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_q && !adv) |=> (busy_q && step_q == $past(step_q)));
  assert_wl_in_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wl_cas_o |-> (busy_q && step_q == WL_IDX));
  assert_turn_in_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_o |-> (busy_q && step_q == DQS_IDX));
endmodule

// File: tb/phy_train_pacer_test.sv
`timescale 1ns/1ps
module phy_train_pacer_test;
  localparam int NS = 4;

  typedef struct packed {
    logic [4:0] n;
    logic       sel;
    logic [4:0] d;
    logic [7:0] d0, d1, d2, d3;
    logic [3:0] flags;
  } vec_t;

  // done_at = 255 means the step never reports done
  localparam vec_t VECS [5] = '{
    '{n: 5'd2, sel: 1'b0, d: 5'd15, d0: 8'd0,   d1: 8'd255, d2: 8'd1,   d3: 8'd255, flags: 4'b1010},
    '{n: 5'd6, sel: 1'b0, d: 5'd5,  d0: 8'd255, d1: 8'd40,  d2: 8'd20,  d3: 8'd3,   flags: 4'b0001},
    '{n: 5'd6, sel: 1'b1, d: 5'd0,  d0: 8'd2,   d1: 8'd255, d2: 8'd255, d3: 8'd0,   flags: 4'b0110},
    '{n: 5'd0, sel: 1'b0, d: 5'd15, d0: 8'd255, d1: 8'd255, d2: 8'd255, d3: 8'd255, flags: 4'b1111},
    '{n: 5'd2, sel: 1'b1, d: 5'd1,  d0: 8'd3,   d1: 8'd3,   d2: 8'd3,   d3: 8'd3,   flags: 4'b0000}
  };

  logic clk = 0, rst_n = 0, start = 0, sel = 0;
  logic [NS-1:0] done = '0;
  logic [4:0] wexp = '0, tdly = '0;
  logic [1:0] step;
  logic [NS-1:0] sstart, tout;
  logic busy, tdone, wl, turn;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  phy_train_pacer uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_done_i(done),
    .wd_exp_i(wexp), .wl_space_sel_i(sel), .turn_dly_i(tdly),
    .step_o(step), .step_start_o(sstart), .busy_o(busy), .train_done_o(tdone),
    .timeout_o(tout), .wl_cas_o(wl), .turn_o(turn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // runs one vector, returns per-step durations and pulse counts
  task automatic run(input vec_t v, output int dur [NS], output int wlc, output int tc,
                     output int total, input bit hold_start, input bit change_cfg);
    int idx, prev;
    logic [7:0] dat [NS];
    dat[0] = v.d0; dat[1] = v.d1; dat[2] = v.d2; dat[3] = v.d3;
    for (int k = 0; k < NS; k++) dur[k] = 0;
    wlc = 0; tc = 0; total = 0; idx = 0; prev = -1;
    wexp = v.n; sel = v.sel; tdly = v.d; start = 1;
    @(negedge clk);
    start = hold_start;
    if (change_cfg) begin wexp = 5'd6; sel = ~v.sel; tdly = 5'd1; end
    chk(busy && step == 0 && sstart == 4'b0001 && !tdone && tout == 0, "R2 start entry",
        {busy, step, sstart, tdone, tout}, 32'b1_00_0001_0_0000);
    while (busy) begin
      if (int'(step) != prev) begin
        chk(sstart == NS'(1) << step, "R6 entry strobe", sstart, 1 << step);
        prev = step; idx = 0;
      end
      done = (idx == dat[step]) ? NS'(1) << step : '0;
      dur[step]++; total++;
      if (wl) begin wlc++; chk(step == 1, "R9 wl in step", step, 1); end
      if (turn) begin tc++; chk(step == 2, "R10 turn in step", step, 2); end
      @(negedge clk);
      done = '0; idx++;
      if (total > 5000) break;
    end
    start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int dur [NS];
    int wlc, tc, total, lim, dat, ed, per;
    vec_t v;
    repeat (3) @(negedge clk);
    chk(!busy && !tdone && tout == 0 && sstart == 0 && !wl && !turn && step == 0,
        "R1 reset state", {busy, tdone, tout, sstart, wl, turn}, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VECS[i]) begin
      v = VECS[i];
      run(v, dur, wlc, tc, total, 1'b0, 1'b0);
      lim = 1 << v.n;
      for (int k = 0; k < NS; k++) begin
        dat = (k == 0) ? v.d0 : (k == 1) ? v.d1 : (k == 2) ? v.d2 : v.d3;
        ed = (dat < lim) ? dat + 1 : lim;
        chk(dur[k] == ed, "R3/R4 step length", dur[k], ed);
      end
      chk(tout == v.flags, "R5 timeout flags", tout, v.flags);
      chk(tdone && !busy, "R7 complete", tdone, 1);
      per = v.sel ? 32 : 16;
      chk(wlc == dur[1] / per, "R9 wl pulse count", wlc, dur[1] / per);
      per = (v.d == 0) ? 1 : v.d;
      chk(tc == dur[2] / per, "R10 turn pulse count", tc, dur[2] / per);
    end

    // R7: complete level held while idle
    repeat (5) @(negedge clk);
    chk(tdone && !busy && tout == 4'b0000, "R7 held idle", tdone, 1);

    // R8: start held high during a run is ignored
    v = '{n: 5'd3, sel: 1'b0, d: 5'd4, d0: 8'd255, d1: 8'd255, d2: 8'd255, d3: 8'd255, flags: 4'b1111};
    run(v, dur, wlc, tc, total, 1'b1, 1'b0);
    chk(total == 32, "R8 start ignored while busy", total, 32);
    chk(tout == 4'b1111, "R8 flags after held start", tout, 15);

    // R11: configuration changes mid-run have no effect
    v = '{n: 5'd1, sel: 1'b0, d: 5'd2, d0: 8'd255, d1: 8'd255, d2: 8'd255, d3: 8'd255, flags: 4'b1111};
    run(v, dur, wlc, tc, total, 1'b0, 1'b1);
    chk(total == 8, "R11 config captured at start", total, 8);
    chk(tc == 1, "R11 turn period captured", tc, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule